// File: doc/BRIEF.md
# Per-ID Completion Reordering Queue

This block sits between the switch and one master port of an interconnect. Each time the switch sends a read or write request to one of the slaves, it reports an issue event that carries the request ID, the index of the target slave and, for reads, the burst length. The block keeps these events in issue order. Completions from the slaves go into one small queue per slave. The block then sends them to the master one at a time, always in the order the requests were issued. This holds even when the master used the same ID towards several slaves, a case where arrival order alone would break the AXI ordering rules.

Reads and writes are kept in separate order FIFOs. The end of a read burst is found by counting delivered beats against the length recorded with the order entry. A write response is a single beat. When the ordering parameter is cleared, the queues and order FIFOs are left out of the path. Completions then pass straight through in arrival order: the lowest-numbered valid slave wins, and a read burst keeps the output until its last beat.

Top module: `cpl_order_q`

## Requirements
- R1: With REORDER_EN=1, read completions leave on the m_r port in the order of their read issue events. A beat from a slave that is not at the head of the order stays in its queue, and m_r_valid stays low until the head slave has data.
- R2: A read issue with length L delivers L+1 beats. m_r_last is 1 only on the final beat, and the beats of the next order entry start only after that beat has been accepted.
- R3: Write responses leave on the m_b port in the order of the write issue events, one beat per issue event.
- R4: Read and write orders are independent: a write response at the head of the write order is delivered while the read head is still waiting, and the reverse also holds.
- R5: rd_iss_ready (and wr_iss_ready) is 0 while ORD_DEPTH entries are outstanding in that order FIFO. It returns to 1 once an entry completes.
- R6: The ready output of each slave is 0 while that slave's queue holds CQ_DEPTH entries. Beats from one slave keep their arrival order.
- R7: After reset both output valids are 0, both issue readies are 1 and every slave ready is 1.
- R8: While an output valid is 1 and its ready is 0, the valid, ID, data/response and last values hold.
- R9: With REORDER_EN=0, both issue readies are 1. Among slaves that are valid in the same cycle, the lowest index is passed first, and a started read burst keeps the output until the beat that carries that slave's last flag.
- R10: Slave i drives bits [i*W +: W] of each flat slave bus. Data and response reach the output unchanged. With REORDER_EN=1 the output ID is the ID of the issue event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_iss_valid | input | 1 | Read issue event valid |
| rd_iss_ready | output | 1 | Read order FIFO can take an event |
| rd_iss_id | input | ID_W | ID of the issued read |
| rd_iss_src | input | SRC_W | Slave index the read was sent to |
| rd_iss_len | input | LEN_W | Burst length minus one |
| wr_iss_valid | input | 1 | Write issue event valid |
| wr_iss_ready | output | 1 | Write order FIFO can take an event |
| wr_iss_id | input | ID_W | ID of the issued write |
| wr_iss_src | input | SRC_W | Slave index the write was sent to |
| s_r_valid | input | NUM_SRC | Read beat valid per slave |
| s_r_ready | output | NUM_SRC | Read beat ready per slave |
| s_r_id | input | NUM_SRC*ID_W | Read ID per slave |
| s_r_data | input | NUM_SRC*DATA_W | Read data per slave |
| s_r_resp | input | NUM_SRC*2 | Read response per slave |
| s_r_last | input | NUM_SRC | Last flag per slave (used when ordering is off) |
| s_b_valid | input | NUM_SRC | Write response valid per slave |
| s_b_ready | output | NUM_SRC | Write response ready per slave |
| s_b_id | input | NUM_SRC*ID_W | Write response ID per slave |
| s_b_resp | input | NUM_SRC*2 | Write response code per slave |
| m_r_valid | output | 1 | Read beat to master valid |
| m_r_ready | input | 1 | Master accepts read beat |
| m_r_id | output | ID_W | Read beat ID |
| m_r_data | output | DATA_W | Read beat data |
| m_r_resp | output | 2 | Read beat response |
| m_r_last | output | 1 | Final beat of the burst |
| m_b_valid | output | 1 | Write response to master valid |
| m_b_ready | input | 1 | Master accepts write response |
| m_b_id | output | ID_W | Write response ID |
| m_b_resp | output | 2 | Write response code |

## Verification
The riskiest overlap is an order FIFO or a slave queue being written and read in the same cycle. This happens when a new issue event is offered while the last beat of the head burst retires its entry, or when a slave pushes a beat into a queue that is being drained. The bench provokes the first case by refilling a full read order while the remaining bursts drain. It provokes the second by feeding the rest of a burst into a queue that has just been full while its head beats leave. Both cases are judged only by the order, count and last flags of the beats logged at the master port, against a list the bench writes down beforehand.

// File: rtl/cpl_order_pkg.sv
package cpl_order_pkg;

    localparam int RESP_W = 2;

    // Index width for a count of n items, never zero.
    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    // Lowest set bit of a request vector (0 when none is set).
    function automatic int first_one(input logic [31:0] v);
        int r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/crq_fifo.sv
module crq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = cpl_order_pkg::idx_w(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

endmodule

// File: rtl/crq_path.sv
module crq_path #(
    parameter int NUM_SRC    = 4,
    parameter int ID_W       = 4,
    parameter int PAY_W      = 34,
    parameter int LEN_W      = 8,
    parameter int ORD_DEPTH  = 8,
    parameter int CQ_DEPTH   = 4,
    parameter bit REORDER_EN = 1'b1,
    localparam int SW        = cpl_order_pkg::idx_w(NUM_SRC)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       iss_valid,
    output logic                       iss_ready,
    input  logic [ID_W-1:0]            iss_id,
    input  logic [SW-1:0]              iss_src,
    input  logic [LEN_W-1:0]           iss_len,
    input  logic [NUM_SRC-1:0]         s_valid,
    output logic [NUM_SRC-1:0]         s_ready,
    input  logic [NUM_SRC*ID_W-1:0]    s_id,
    input  logic [NUM_SRC*PAY_W-1:0]   s_pay,
    input  logic [NUM_SRC-1:0]         s_last,
    output logic                       m_valid,
    input  logic                       m_ready,
    output logic [ID_W-1:0]            m_id,
    output logic [PAY_W-1:0]           m_pay,
    output logic                       m_last
);
    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [SW-1:0]    src;
        logic [LEN_W-1:0] len;
    } ord_t;

    localparam int OW = $bits(ord_t);

    // ---------------- ordered path ----------------
    ord_t               ord_in, ord_head;
    logic               ord_empty, ord_full, ord_push, ord_pop;
    logic [NUM_SRC-1:0] q_empty, q_full, q_push, q_pop;
    logic [PAY_W-1:0]   q_dout [NUM_SRC];
    logic [LEN_W-1:0]   beat_cnt;
    logic               ro_valid, ro_last, ro_fire;

    assign ord_in   = '{id: iss_id, src: iss_src, len: iss_len};
    assign ord_push = REORDER_EN && iss_valid && !ord_full;

    crq_fifo #(.W(OW), .DEPTH(ORD_DEPTH)) u_ord (
        .clk   (clk),
        .rst   (rst),
        .push  (ord_push),
        .din   (ord_in),
        .pop   (ord_pop),
        .dout  (ord_head),
        .empty (ord_empty),
        .full  (ord_full)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_queue
        assign q_push[i] = REORDER_EN && s_valid[i] && !q_full[i];
        assign q_pop[i]  = ro_fire && (ord_head.src == SW'(i));

        crq_fifo #(.W(PAY_W), .DEPTH(CQ_DEPTH)) u_q (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[i]),
            .din   (s_pay[i*PAY_W +: PAY_W]),
            .pop   (q_pop[i]),
            .dout  (q_dout[i]),
            .empty (q_empty[i]),
            .full  (q_full[i])
        );
    end

    assign ro_valid = !ord_empty && !q_empty[ord_head.src];
    assign ro_last  = (beat_cnt == ord_head.len);
    assign ro_fire  = REORDER_EN && ro_valid && m_ready;
    assign ord_pop  = ro_fire && ro_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_cnt <= '0;
        end else if (ro_fire) begin
            beat_cnt <= ro_last ? '0 : beat_cnt + LEN_W'(1);
        end
    end

    // ---------------- pass-through path ----------------
    logic          bp_busy;
    logic [SW-1:0] bp_src, bp_sel;
    logic          bp_fire;

    assign bp_sel  = bp_busy ? bp_src : SW'(cpl_order_pkg::first_one(32'(s_valid)));
    assign bp_fire = !REORDER_EN && s_valid[bp_sel] && m_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            bp_busy <= 1'b0;
            bp_src  <= '0;
        end else if (bp_fire) begin
            bp_busy <= !s_last[bp_sel];
            bp_src  <= bp_sel;
        end
    end

    // ---------------- output selection ----------------
    always_comb begin
        if (REORDER_EN) begin
            iss_ready = !ord_full;
            s_ready   = ~q_full;
            m_valid   = ro_valid;
            m_id      = ord_head.id;
            m_pay     = q_dout[ord_head.src];
            m_last    = ro_last;
        end else begin
            iss_ready = 1'b1;
            s_ready   = '0;
            s_ready[bp_sel] = m_ready;
            m_valid   = s_valid[bp_sel];
            m_id      = s_id[bp_sel*ID_W +: ID_W];
            m_pay     = s_pay[bp_sel*PAY_W +: PAY_W];
            m_last    = s_last[bp_sel];
        end
    end

endmodule

// File: rtl/cpl_order_q.sv
module cpl_order_q #(
    parameter int NUM_SRC    = 4,
    parameter int ID_W       = 4,
    parameter int DATA_W     = 32,
    parameter int LEN_W      = 8,
    parameter int ORD_DEPTH  = 8,
    parameter int CQ_DEPTH   = 4,
    parameter bit REORDER_EN = 1'b1,
    localparam int SRC_W     = cpl_order_pkg::idx_w(NUM_SRC)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       rd_iss_valid,
    output logic                       rd_iss_ready,
    input  logic [ID_W-1:0]            rd_iss_id,
    input  logic [SRC_W-1:0]           rd_iss_src,
    input  logic [LEN_W-1:0]           rd_iss_len,
    input  logic                       wr_iss_valid,
    output logic                       wr_iss_ready,
    input  logic [ID_W-1:0]            wr_iss_id,
    input  logic [SRC_W-1:0]           wr_iss_src,
    input  logic [NUM_SRC-1:0]         s_r_valid,
    output logic [NUM_SRC-1:0]         s_r_ready,
    input  logic [NUM_SRC*ID_W-1:0]    s_r_id,
    input  logic [NUM_SRC*DATA_W-1:0]  s_r_data,
    input  logic [NUM_SRC*2-1:0]       s_r_resp,
    input  logic [NUM_SRC-1:0]         s_r_last,
    input  logic [NUM_SRC-1:0]         s_b_valid,
    output logic [NUM_SRC-1:0]         s_b_ready,
    input  logic [NUM_SRC*ID_W-1:0]    s_b_id,
    input  logic [NUM_SRC*2-1:0]       s_b_resp,
    output logic                       m_r_valid,
    input  logic                       m_r_ready,
    output logic [ID_W-1:0]            m_r_id,
    output logic [DATA_W-1:0]          m_r_data,
    output logic [1:0]                 m_r_resp,
    output logic                       m_r_last,
    output logic                       m_b_valid,
    input  logic                       m_b_ready,
    output logic [ID_W-1:0]            m_b_id,
    output logic [1:0]                 m_b_resp
);
    import cpl_order_pkg::*;

    localparam int RPAY_W = DATA_W + RESP_W;

    logic [NUM_SRC*RPAY_W-1:0] r_pay;
    logic [RPAY_W-1:0]         r_out;
    logic                      wr_last;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_pack
        assign r_pay[i*RPAY_W +: RPAY_W] = {s_r_resp[i*RESP_W +: RESP_W],
                                            s_r_data[i*DATA_W +: DATA_W]};
    end

    crq_path #(
        .NUM_SRC    (NUM_SRC),
        .ID_W       (ID_W),
        .PAY_W      (RPAY_W),
        .LEN_W      (LEN_W),
        .ORD_DEPTH  (ORD_DEPTH),
        .CQ_DEPTH   (CQ_DEPTH),
        .REORDER_EN (REORDER_EN)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (rd_iss_valid),
        .iss_ready (rd_iss_ready),
        .iss_id    (rd_iss_id),
        .iss_src   (rd_iss_src),
        .iss_len   (rd_iss_len),
        .s_valid   (s_r_valid),
        .s_ready   (s_r_ready),
        .s_id      (s_r_id),
        .s_pay     (r_pay),
        .s_last    (s_r_last),
        .m_valid   (m_r_valid),
        .m_ready   (m_r_ready),
        .m_id      (m_r_id),
        .m_pay     (r_out),
        .m_last    (m_r_last)
    );

    assign m_r_data = r_out[DATA_W-1:0];
    assign m_r_resp = r_out[DATA_W +: RESP_W];

    crq_path #(
        .NUM_SRC    (NUM_SRC),
        .ID_W       (ID_W),
        .PAY_W      (RESP_W),
        .LEN_W      (1),
        .ORD_DEPTH  (ORD_DEPTH),
        .CQ_DEPTH   (CQ_DEPTH),
        .REORDER_EN (REORDER_EN)
    ) u_wr (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (wr_iss_valid),
        .iss_ready (wr_iss_ready),
        .iss_id    (wr_iss_id),
        .iss_src   (wr_iss_src),
        .iss_len   (1'b0),
        .s_valid   (s_b_valid),
        .s_ready   (s_b_ready),
        .s_id      (s_b_id),
        .s_pay     (s_b_resp),
        .s_last    ({NUM_SRC{1'b1}}),
        .m_valid   (m_b_valid),
        .m_ready   (m_b_ready),
        .m_id      (m_b_id),
        .m_pay     (m_b_resp),
        .m_last    (wr_last)
    );

endmodule

// File: rtl/cpl_order_q_chk.sv
module cpl_order_q_chk #(
    parameter int NUM_SRC    = 4,
    parameter int ID_W       = 4,
    parameter int DATA_W     = 32,
    parameter int ORD_DEPTH  = 8,
    parameter bit REORDER_EN = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic               rd_iss_valid,
    input logic               rd_iss_ready,
    input logic               wr_iss_valid,
    input logic               wr_iss_ready,
    input logic [NUM_SRC-1:0] s_r_ready,
    input logic [NUM_SRC-1:0] s_b_ready,
    input logic               m_r_valid,
    input logic               m_r_ready,
    input logic [ID_W-1:0]    m_r_id,
    input logic [DATA_W-1:0]  m_r_data,
    input logic               m_r_last,
    input logic               m_b_valid,
    input logic               m_b_ready,
    input logic [ID_W-1:0]    m_b_id,
    input logic [1:0]         m_b_resp,
    input logic               wr_last
);
    logic [15:0] rd_out, wr_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_out <= '0;
            wr_out <= '0;
        end else if (REORDER_EN) begin
            rd_out <= rd_out + 16'(rd_iss_valid && rd_iss_ready)
                             - 16'(m_r_valid && m_r_ready && m_r_last);
            wr_out <= wr_out + 16'(wr_iss_valid && wr_iss_ready)
                             - 16'(m_b_valid && m_b_ready);
        end
    end

    p_rd_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        rd_out <= 16'(ORD_DEPTH));
    p_rd_full_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (REORDER_EN && !rd_iss_ready) |-> (rd_out == 16'(ORD_DEPTH)));
    p_wr_full_stall_r5: assert property (@(posedge clk) disable iff (rst)
        (REORDER_EN && !wr_iss_ready) |-> (wr_out == 16'(ORD_DEPTH)));
    p_rd_needs_order_r1: assert property (@(posedge clk) disable iff (rst)
        (REORDER_EN && m_r_valid) |-> (rd_out != 16'd0));
    p_wr_needs_order_r3: assert property (@(posedge clk) disable iff (rst)
        (REORDER_EN && m_b_valid) |-> (wr_out != 16'd0));
    p_wr_single_beat_r3: assert property (@(posedge clk) disable iff (rst)
        m_b_valid |-> wr_last);
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (REORDER_EN && m_r_valid && !m_r_ready) |=>
        (m_r_valid && $stable(m_r_data) && $stable(m_r_id) && $stable(m_r_last)));
    p_wr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (REORDER_EN && m_b_valid && !m_b_ready) |=>
        (m_b_valid && $stable(m_b_id) && $stable(m_b_resp)));
    p_bp_one_rd_r9: assert property (@(posedge clk) disable iff (rst)
        !REORDER_EN |-> $onehot0(s_r_ready));
    p_bp_one_wr_r9: assert property (@(posedge clk) disable iff (rst)
        !REORDER_EN |-> $onehot0(s_b_ready));

endmodule

bind cpl_order_q cpl_order_q_chk #(
    .NUM_SRC    (NUM_SRC),
    .ID_W       (ID_W),
    .DATA_W     (DATA_W),
    .ORD_DEPTH  (ORD_DEPTH),
    .REORDER_EN (REORDER_EN)
) u_chk (.*);

// File: tb/cpl_order_q_bench.sv
module cpl_order_q_bench;
    localparam int NS = 4;
    localparam int IW = 4;
    localparam int DW = 16;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // main instance stimulus
    logic          rd_iss_valid = 0, wr_iss_valid = 0;
    logic          rd_iss_ready, wr_iss_ready;
    logic [IW-1:0] rd_iss_id = 0, wr_iss_id = 0;
    logic [1:0]    rd_iss_src = 0, wr_iss_src = 0;
    logic [LW-1:0] rd_iss_len = 0;
    logic [NS-1:0] s_r_valid = 0, s_r_last = 0, s_b_valid = 0;
    logic [NS-1:0] s_r_ready, s_b_ready;
    logic [NS*IW-1:0] s_r_id = 0, s_b_id = 0;
    logic [NS*DW-1:0] s_r_data = 0;
    logic [NS*2-1:0]  s_r_resp = 0, s_b_resp = 0;
    logic          m_r_valid, m_r_last, m_b_valid;
    logic          m_r_ready = 1, m_b_ready = 1;
    logic [IW-1:0] m_r_id, m_b_id;
    logic [DW-1:0] m_r_data;
    logic [1:0]    m_r_resp, m_b_resp;

    // pass-through instance stimulus
    logic          bp_rd_iss_ready, bp_wr_iss_ready;
    logic [NS-1:0] bp_s_r_valid = 0, bp_s_r_last = 0, bp_s_r_ready, bp_s_b_ready;
    logic [NS*DW-1:0] bp_s_r_data = 0;
    logic          bp_m_r_valid, bp_m_r_last, bp_m_b_valid;
    logic [IW-1:0] bp_m_r_id, bp_m_b_id;
    logic [DW-1:0] bp_m_r_data;
    logic [1:0]    bp_m_r_resp, bp_m_b_resp;

    cpl_order_q #(.NUM_SRC(NS), .ID_W(IW), .DATA_W(DW), .LEN_W(LW),
                  .ORD_DEPTH(4), .CQ_DEPTH(2), .REORDER_EN(1'b1)) u_cpl_order_q (
        .clk(clk), .rst(rst),
        .rd_iss_valid(rd_iss_valid), .rd_iss_ready(rd_iss_ready), .rd_iss_id(rd_iss_id),
        .rd_iss_src(rd_iss_src), .rd_iss_len(rd_iss_len),
        .wr_iss_valid(wr_iss_valid), .wr_iss_ready(wr_iss_ready), .wr_iss_id(wr_iss_id),
        .wr_iss_src(wr_iss_src),
        .s_r_valid(s_r_valid), .s_r_ready(s_r_ready), .s_r_id(s_r_id), .s_r_data(s_r_data),
        .s_r_resp(s_r_resp), .s_r_last(s_r_last),
        .s_b_valid(s_b_valid), .s_b_ready(s_b_ready), .s_b_id(s_b_id), .s_b_resp(s_b_resp),
        .m_r_valid(m_r_valid), .m_r_ready(m_r_ready), .m_r_id(m_r_id), .m_r_data(m_r_data),
        .m_r_resp(m_r_resp), .m_r_last(m_r_last),
        .m_b_valid(m_b_valid), .m_b_ready(m_b_ready), .m_b_id(m_b_id), .m_b_resp(m_b_resp)
    );

    cpl_order_q #(.NUM_SRC(NS), .ID_W(IW), .DATA_W(DW), .LEN_W(LW),
                  .ORD_DEPTH(4), .CQ_DEPTH(2), .REORDER_EN(1'b0)) u_cpl_order_q_bypass (
        .clk(clk), .rst(rst),
        .rd_iss_valid(1'b0), .rd_iss_ready(bp_rd_iss_ready), .rd_iss_id('0),
        .rd_iss_src('0), .rd_iss_len('0),
        .wr_iss_valid(1'b0), .wr_iss_ready(bp_wr_iss_ready), .wr_iss_id('0), .wr_iss_src('0),
        .s_r_valid(bp_s_r_valid), .s_r_ready(bp_s_r_ready), .s_r_id('0), .s_r_data(bp_s_r_data),
        .s_r_resp('0), .s_r_last(bp_s_r_last),
        .s_b_valid('0), .s_b_ready(bp_s_b_ready), .s_b_id('0), .s_b_resp('0),
        .m_r_valid(bp_m_r_valid), .m_r_ready(1'b1), .m_r_id(bp_m_r_id), .m_r_data(bp_m_r_data),
        .m_r_resp(bp_m_r_resp), .m_r_last(bp_m_r_last),
        .m_b_valid(bp_m_b_valid), .m_b_ready(1'b1), .m_b_id(bp_m_b_id), .m_b_resp(bp_m_b_resp)
    );

    // output logs, filled at the falling edge before each accepting rising edge
    logic [DW-1:0] rl_data [64];
    logic [IW-1:0] rl_id   [64];
    logic [1:0]    rl_resp [64];
    logic          rl_last [64];
    logic [IW-1:0] bl_id   [64];
    logic [1:0]    bl_resp [64];
    logic [DW-1:0] pl_data [64];
    logic          pl_last [64];
    int rn = 0, bn = 0, pn = 0;

    always @(negedge clk) begin
        if (!rst && m_r_valid && m_r_ready && rn < 64) begin
            rl_data[rn] = m_r_data; rl_id[rn] = m_r_id;
            rl_resp[rn] = m_r_resp; rl_last[rn] = m_r_last; rn++;
        end
        if (!rst && m_b_valid && m_b_ready && bn < 64) begin
            bl_id[bn] = m_b_id; bl_resp[bn] = m_b_resp; bn++;
        end
        if (!rst && bp_m_r_valid && pn < 64) begin
            pl_data[pn] = bp_m_r_data; pl_last[pn] = bp_m_r_last; pn++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic issue_rd(input int id, input int src, input int len);
        @(posedge clk); #1;
        rd_iss_valid = 1; rd_iss_id = IW'(id); rd_iss_src = 2'(src); rd_iss_len = LW'(len);
        @(negedge clk);
        while (!rd_iss_ready) @(negedge clk);
        @(posedge clk); #1;
        rd_iss_valid = 0;
    endtask

    task automatic issue_wr(input int id, input int src);
        @(posedge clk); #1;
        wr_iss_valid = 1; wr_iss_id = IW'(id); wr_iss_src = 2'(src);
        @(negedge clk);
        while (!wr_iss_ready) @(negedge clk);
        @(posedge clk); #1;
        wr_iss_valid = 0;
    endtask

    task automatic send_r(input int src, input int id, input int data, input int resp, input bit last);
        @(posedge clk); #1;
        s_r_valid[src] = 1; s_r_id[src*IW +: IW] = IW'(id);
        s_r_data[src*DW +: DW] = DW'(data); s_r_resp[src*2 +: 2] = 2'(resp);
        s_r_last[src] = last;
        @(negedge clk);
        while (!s_r_ready[src]) @(negedge clk);
        @(posedge clk); #1;
        s_r_valid[src] = 0;
    endtask

    task automatic send_b(input int src, input int id, input int resp);
        @(posedge clk); #1;
        s_b_valid[src] = 1; s_b_id[src*IW +: IW] = IW'(id); s_b_resp[src*2 +: 2] = 2'(resp);
        @(negedge clk);
        while (!s_b_ready[src]) @(negedge clk);
        @(posedge clk); #1;
        s_b_valid[src] = 0;
    endtask

    task automatic send_bp(input int src, input int data, input bit last);
        @(posedge clk); #1;
        bp_s_r_valid[src] = 1; bp_s_r_data[src*DW +: DW] = DW'(data); bp_s_r_last[src] = last;
        @(negedge clk);
        while (!bp_s_r_ready[src]) @(negedge clk);
        @(posedge clk); #1;
        bp_s_r_valid[src] = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R7 m_r_valid", m_r_valid, 0);
        check("R7 m_b_valid", m_b_valid, 0);
        check("R7 rd_iss_ready", rd_iss_ready, 1);
        check("R7 wr_iss_ready", wr_iss_ready, 1);
        check("R7 s_r_ready", s_r_ready, 4'hF);
        check("R7 s_b_ready", s_b_ready, 4'hF);
    endtask

    task automatic t_order;
        int b0;
        b0 = rn;
        issue_rd(3, 2, 0);
        issue_rd(3, 0, 0);
        send_r(0, 3, 16'hA000, 0, 1);
        idle(3); @(negedge clk);
        check("R1 non-head waits", m_r_valid, 0);
        send_r(2, 3, 16'hA020, 1, 1);
        idle(4);
        check("R1 count", rn - b0, 2);
        check("R1 first", rl_data[b0], 16'hA020);
        check("R1 second", rl_data[b0+1], 16'hA000);
        check("R10 resp", rl_resp[b0], 1);
        check("R10 id", rl_id[b0+1], 3);
    endtask

    task automatic t_burst;
        int b0;
        b0 = rn;
        issue_rd(5, 1, 1);
        issue_rd(6, 3, 0);
        send_r(3, 6, 16'hB030, 0, 1);
        send_r(1, 5, 16'hB010, 0, 0);
        send_r(1, 5, 16'hB011, 0, 1);
        idle(4);
        check("R2 count", rn - b0, 3);
        check("R2 beat0", {rl_data[b0], 15'd0, rl_last[b0]}, {16'hB010, 16'd0});
        check("R2 beat1", {rl_data[b0+1], 15'd0, rl_last[b0+1]}, {16'hB011, 16'd1});
        check("R2 next entry", {rl_data[b0+2], 15'd0, rl_last[b0+2]}, {16'hB030, 16'd1});
        check("R2 next id", rl_id[b0+2], 6);
    endtask

    task automatic t_write;
        int r0, w0;
        r0 = rn; w0 = bn;
        issue_wr(5, 1);
        issue_wr(6, 0);
        issue_rd(7, 2, 0);
        send_b(0, 6, 0);
        send_b(1, 5, 2);
        idle(4);
        check("R3 count", bn - w0, 2);
        check("R3 first", {bl_id[w0], 2'b0, bl_resp[w0]}, {4'd5, 2'b0, 2'd2});
        check("R3 second", {bl_id[w0+1], 2'b0, bl_resp[w0+1]}, {4'd6, 2'b0, 2'd0});
        check("R4 read still waiting", rn - r0, 0);
        send_r(2, 7, 16'hC020, 0, 1);
        idle(3);
        check("R4 read after", rl_data[r0], 16'hC020);
    endtask

    task automatic t_full;
        int b0;
        b0 = rn;
        for (int i = 0; i < 4; i++) issue_rd(8 + i, i, 0);
        @(negedge clk);
        check("R5 full", rd_iss_ready, 0);
        send_r(0, 8, 16'hD000, 0, 1);
        idle(2); @(negedge clk);
        check("R5 freed", rd_iss_ready, 1);
        fork
            issue_rd(12, 0, 0);
            begin
                send_r(1, 9, 16'hD010, 0, 1);
                send_r(2, 10, 16'hD020, 0, 1);
                send_r(3, 11, 16'hD030, 0, 1);
            end
        join
        send_r(0, 12, 16'hD001, 0, 1);
        idle(4);
        check("R5 count", rn - b0, 5);
        for (int i = 0; i < 4; i++) check("R1 drain order", rl_data[b0+i], 16'hD000 + 16'(i*16));
        check("R5 refill", rl_data[b0+4], 16'hD001);
    endtask

    task automatic t_qfull;
        int b0;
        b0 = rn;
        issue_rd(1, 0, 0);
        issue_rd(2, 1, 3);
        send_r(1, 2, 16'hE010, 0, 0);
        send_r(1, 2, 16'hE011, 0, 0);
        @(negedge clk);
        check("R6 queue full", s_r_ready[1], 0);
        check("R6 other ready", s_r_ready[2], 1);
        send_r(0, 1, 16'hE000, 0, 1);
        send_r(1, 2, 16'hE012, 0, 0);
        send_r(1, 2, 16'hE013, 0, 1);
        idle(4);
        check("R6 count", rn - b0, 5);
        check("R6 head", rl_data[b0], 16'hE000);
        for (int i = 0; i < 4; i++) begin
            check("R6 beat order", rl_data[b0+1+i], 16'hE010 + 16'(i));
            check("R2 last flag", rl_last[b0+1+i], (i == 3) ? 1 : 0);
        end
    endtask

    task automatic t_stall;
        logic [DW-1:0] d0;
        int b0;
        b0 = rn;
        m_r_ready = 0;
        issue_rd(9, 2, 0);
        send_r(2, 9, 16'hF020, 3, 1);
        @(negedge clk);
        d0 = m_r_data;
        check("R8 valid", m_r_valid, 1);
        idle(3); @(negedge clk);
        check("R8 held valid", m_r_valid, 1);
        check("R8 held data", m_r_data, d0);
        check("R8 held id", m_r_id, 9);
        @(posedge clk); #1;
        m_r_ready = 1;
        idle(3);
        check("R8 one delivery", rn - b0, 1);
    endtask

    task automatic t_bypass;
        int b0;
        b0 = pn;
        @(negedge clk);
        check("R9 issue ready", {bp_rd_iss_ready, bp_wr_iss_ready}, 2'b11);
        send_bp(3, 16'h3000, 0);
        fork
            send_bp(0, 16'h0000, 1);
            send_bp(3, 16'h3001, 1);
        join
        fork
            send_bp(1, 16'h1000, 1);
            send_bp(3, 16'h3002, 1);
        join
        idle(3);
        check("R9 count", pn - b0, 5);
        check("R9 burst start", pl_data[b0], 16'h3000);
        check("R9 burst lock", pl_data[b0+1], 16'h3001);
        check("R9 after lock", pl_data[b0+2], 16'h0000);
        check("R9 low index first", pl_data[b0+3], 16'h1000);
        check("R9 then high", pl_data[b0+4], 16'h3002);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        #1 rst = 0;
        t_reset;
        t_order;
        t_burst;
        t_write;
        t_full;
        t_qfull;
        t_stall;
        t_bypass;
        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule